// File: doc/BRIEF.md
# Self-Resynchronizing Divide-by-Four Clock Generator

This block lives in a single fast clock domain that runs four times faster than a slower reference clock. The block does not pass the slow reference straight through. It makes its own quarter-rate square wave with a free-running twisted-ring register. The reference is synchronized and shifted into a window register of the same width, and the two windows are compared on every fast cycle. While they agree, the generated clock runs on by itself, so a stray disturbance on the reference does not reach the output.

When the windows disagree for several cycles in a row, a local resynchronization takes place. The generated register is loaded with the reference window as it stands after the current edge, a one-cycle pulse is raised and a saturating event counter is incremented. After the external reset is released, the block waits until the reference window holds only valid samples and then performs one such local resynchronization. This sets the starting phase.

A typical use is to derive a quiet slow clock in a chip whose slow clock is delivered over a noisy link while a clean fast clock comes from a PLL. The counter tells how often the slow clock had to be realigned.

Top module: `div4_resync`

## Requirements
- R1: While `rst_ni` is low, `div_clk_o`, `resync_o` and `resync_cnt_o` are all 0, whatever `ref_clk_i` does.
- R2: After `rst_ni` rises, the first local resynchronization happens at rising edge number SYNC_STAGES+SR_W, which is the 6th edge with the defaults. `resync_o` is high after that edge and `resync_cnt_o` reads 1.
- R3: With a clean reference (high for 2 and low for 2 fast cycles), from the 7th edge after reset release onward, `div_clk_o` after edge k equals the value of `ref_clk_i` sampled at edge k-4.
- R4: A reference sample that is inverted for a single fast cycle does not alter the `div_clk_o` waveform at any cycle.
- R5: A local resynchronization is caused only by MISS_LIMIT (4) consecutive cycles on which the generated and reference windows differ. If the first differing sample is taken at edge j, the pulse is high after edge j+6.
- R6: A local resynchronization loads the generated register with the reference window of the same edge. After the reference phase is inverted starting at edge j, `div_clk_o` after edge k follows the new reference (sample of edge k-4) for every k from j+7 on.
- R7: `resync_o` is high for exactly one fast cycle per local resynchronization and low at all other times.
- R8: `resync_cnt_o` rises by exactly one on the same edge that raises `resync_o`, and it does not change at any other time.
- R9: `resync_cnt_o` stops at its all-ones value (2^CNT_W-1) and stays there through later local resynchronizations.
- R10: Pulling `rst_ni` low during operation clears `resync_cnt_o` to 0. The next release repeats the start-up sequence of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock (four times the reference rate) |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with clk_i |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| div_clk_o | output | 1 | Registered generated quarter-rate clock |
| resync_o | output | 1 | One-cycle pulse on each local resynchronization |
| resync_cnt_o | output | CNT_W (16) | Saturating count of local resynchronizations |

## Verification
Results arrive at different depths of the pipeline. The generated clock trails the reference sample by four rising edges. A disturbance first sampled at edge j raises the pulse and the count after edge j+6, and after a phase inversion the new phase appears at the output from edge j+7. The bench numbers each rising edge from reset release, drives the reference and samples the outputs at falling edges, and computes every expected value from that edge index. The driver queues each expected pulse with its edge number, and the monitor compares the pulse and the count at exactly that edge. It also checks the clock output on every cycle against an ideal square wave whose phase changes at the edge where the realignment becomes visible.

// File: rtl/div4_resync_pkg.sv
package div4_resync_pkg;

  // Controller phase: waiting for a full reference window, or tracking.
  typedef enum logic {
    PH_BOOT = 1'b0,
    PH_RUN  = 1'b1
  } ctrl_phase_e;

endpackage

// File: rtl/div4_ref_sampler.sv
module div4_ref_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int SR_W        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_clk_i,
  output logic [SR_W-1:0] ref_sr_o,
  output logic [SR_W-1:0] ref_next_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SR_W-1:0]        win_q,  win_d;

  // next-state: synchronizer chain, then window shift
  always_comb begin
    sync_d[0] = ref_clk_i;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    win_d = {win_q[SR_W-2:0], sync_q[SYNC_STAGES-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      win_q  <= '0;
    end else begin
      sync_q <= sync_d;
      win_q  <= win_d;
    end
  end

  assign ref_sr_o   = win_q;
  assign ref_next_o = win_d;

endmodule

// File: rtl/div4_twist_gen.sv
module div4_twist_gen #(
  parameter int SR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] load_val_i,
  output logic [SR_W-1:0] gen_sr_o,
  output logic            div_clk_o
);

  logic [SR_W-1:0] ring_q, ring_d;
  logic            clk_q,  clk_d;

  // next-state: twisted ring (new LSB is the inverse of bit 1) or reload
  always_comb begin
    if (load_i) begin
      ring_d = load_val_i;
    end else begin
      ring_d = {ring_q[SR_W-2:0], ~ring_q[1]};
    end
    clk_d = ring_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
      clk_q  <= 1'b0;
    end else begin
      ring_q <= ring_d;
      clk_q  <= clk_d;
    end
  end

  assign gen_sr_o  = ring_q;
  assign div_clk_o = clk_q;

endmodule

// File: rtl/div4_resync_ctrl.sv
module div4_resync_ctrl
  import div4_resync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SR_W        = 4,
  parameter int MISS_LIMIT  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SR_W-1:0] gen_sr_i,
  input  logic [SR_W-1:0] ref_sr_i,
  output logic            load_o,
  output logic            pulse_o
);

  localparam int FILL = SYNC_STAGES + SR_W;
  localparam int BW   = $clog2(FILL + 1);
  localparam int MW   = $clog2(MISS_LIMIT + 1);

  ctrl_phase_e   ph_q,    ph_d;
  logic [BW-1:0] boot_q,  boot_d;
  logic [MW-1:0] miss_q,  miss_d;
  logic          pulse_q, pulse_d;
  logic          mismatch, boot_done, streak_done;

  always_comb begin
    mismatch    = (ph_q == PH_RUN) && (gen_sr_i != ref_sr_i);
    boot_done   = (ph_q == PH_BOOT) && (boot_q == BW'(FILL - 1));
    streak_done = mismatch && (miss_q == MW'(MISS_LIMIT - 1));
    load_o      = boot_done || streak_done;

    boot_d = (ph_q == PH_BOOT) ? boot_q + BW'(1) : boot_q;
    ph_d   = boot_done ? PH_RUN : ph_q;

    // any matching cycle or any reload clears the streak
    if (load_o || !mismatch) begin
      miss_d = '0;
    end else begin
      miss_d = miss_q + MW'(1);
    end
    pulse_d = load_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_BOOT;
      boot_q  <= '0;
      miss_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      boot_q  <= boot_d;
      miss_q  <= miss_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  assert_no_load_on_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_RUN) && (gen_sr_i == ref_sr_i)) |-> !load_o);

endmodule

// File: rtl/div4_sat_counter.sv
module div4_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_at_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/div4_resync.sv
module div4_resync #(
  parameter int SYNC_STAGES = 2,
  parameter int SR_W        = 4,
  parameter int MISS_LIMIT  = 4,
  parameter int CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  output logic             div_clk_o,
  output logic             resync_o,
  output logic [CNT_W-1:0] resync_cnt_o
);

  logic [SR_W-1:0] ref_sr, ref_next, gen_sr;
  logic            load;

  div4_ref_sampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .SR_W       (SR_W)
  ) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .ref_sr_o  (ref_sr),
    .ref_next_o(ref_next)
  );

  div4_twist_gen #(
    .SR_W(SR_W)
  ) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(ref_next),
    .gen_sr_o  (gen_sr),
    .div_clk_o (div_clk_o)
  );

  div4_resync_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .SR_W       (SR_W),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gen_sr_i(gen_sr),
    .ref_sr_i(ref_sr),
    .load_o  (load),
    .pulse_o (resync_o)
  );

  div4_sat_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (load),
    .cnt_o (resync_cnt_o)
  );

  // a reload leaves the two windows equal on the following cycle
  assert_aligned_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (gen_sr == ref_sr));

  // the count only moves together with the pulse, and by one
  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resync_cnt_o != $past(resync_cnt_o)) |->
      (resync_o && (resync_cnt_o == $past(resync_cnt_o) + CNT_W'(1))));

endmodule

// File: tb/div4_resync_tb.sv
module div4_resync_tb;

  localparam int CNT_W = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_clk_i = 1'b0;
  logic             div_clk_o;
  logic             resync_o;
  logic [CNT_W-1:0] resync_cnt_o;

  div4_resync #(.CNT_W(CNT_W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_clk_i   (ref_clk_i),
    .div_clk_o   (div_clk_o),
    .resync_o    (resync_o),
    .resync_cnt_o(resync_cnt_o)
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  int    errors = 0, checks = 0;
  int    k = 0;                       // rising edges since release
  int    ref_off = 0, off_old = 0, off_new = 0, sw_k = 0;
  int    glitch_k = -100;
  int    exp_cnt = 0;
  int    pulse_q[$];
  string tag_q[$];
  string clk_tag = "R3";
  bit    mon_en = 0, done = 0;

  always @(posedge clk_i) begin
    if (rst_ni) k <= k + 1;
    else        k <= 0;
  end

  function automatic bit wave(int t);
    return (((t % 4) + 4) % 4) >= 2;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, k, act, exp_v);
    end
  endtask

  // monitor: pops expected pulses, tracks the count, checks the clock
  always @(negedge clk_i) begin : monitor
    int kk;
    bit ec;
    kk = k;
    if (mon_en && rst_ni && kk >= 1) begin
      if (kk >= 7) begin
        ec = wave(kk - 4 + ((kk >= sw_k) ? off_new : off_old));
        check(div_clk_o == ec, clk_tag, "div_clk_o", int'(div_clk_o), int'(ec));
      end
      if (pulse_q.size() > 0 && pulse_q[0] == kk) begin
        check(resync_o == 1'b1, tag_q[0], "resync_o due", int'(resync_o), 1);
        void'(pulse_q.pop_front());
        void'(tag_q.pop_front());
        if (exp_cnt < CMAX) exp_cnt++;
      end else begin
        check(resync_o == 1'b0, "R7", "resync_o idle", int'(resync_o), 0);
      end
      check(int'(resync_cnt_o) == exp_cnt, (exp_cnt == CMAX) ? "R9" : "R8",
            "resync_cnt_o", int'(resync_cnt_o), exp_cnt);
    end
  end

  // driver
  task automatic step_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      ref_clk_i = wave(k + 1 + ref_off) ^ ((k + 1) == glitch_k);
    end
  endtask

  task automatic inject_glitch();
    glitch_k = k + 2;
    pulse_q.push_back(glitch_k + 6);
    tag_q.push_back("R5");
    clk_tag = "R4";
    step_cycles(16);
    clk_tag = "R3";
  endtask

  task automatic invert_phase();
    int j;
    j       = k + 2;
    off_old = off_new;
    ref_off = ref_off + 2;
    off_new = ref_off;
    sw_k    = j + 7;
    pulse_q.push_back(j + 6);
    tag_q.push_back("R5");
    clk_tag = "R6";
    step_cycles(20);
    clk_tag = "R3";
  endtask

  task automatic start_run(string boot_tag);
    pulse_q.delete();
    tag_q.delete();
    exp_cnt  = 0;
    sw_k     = 0;
    off_old  = ref_off;
    off_new  = ref_off;
    glitch_k = -100;
    pulse_q.push_back(6);
    tag_q.push_back(boot_tag);
    mon_en = 1;
    @(negedge clk_i);
    rst_ni    = 1'b1;
    ref_clk_i = wave(1 + ref_off);
  endtask

  initial begin
    rst_ni = 1'b0;
    step_cycles(5);  // reference toggles while reset is held
    check(div_clk_o == 1'b0, "R1", "div_clk_o in reset", int'(div_clk_o), 0);
    check(resync_o == 1'b0, "R1", "resync_o in reset", int'(resync_o), 0);
    check(resync_cnt_o == '0, "R1", "resync_cnt_o in reset", int'(resync_cnt_o), 0);

    start_run("R2");
    step_cycles(40);
    check(int'(resync_cnt_o) == 1, "R2", "count after start-up", int'(resync_cnt_o), 1);

    inject_glitch();
    step_cycles(8);
    invert_phase();
    step_cycles(8);
    check(int'(resync_cnt_o) == 3, "R8", "count after inversion", int'(resync_cnt_o), 3);

    for (int g = 0; g < 6; g++) begin
      inject_glitch();
    end
    step_cycles(8);
    check(int'(resync_cnt_o) == CMAX, "R9", "count saturated", int'(resync_cnt_o), CMAX);

    // reset in the middle of operation
    @(negedge clk_i);
    rst_ni = 1'b0;
    mon_en = 0;
    step_cycles(3);
    check(resync_cnt_o == '0, "R10", "count cleared", int'(resync_cnt_o), 0);
    check(div_clk_o == 1'b0, "R10", "clock held low", int'(div_clk_o), 0);
    check(resync_o == 1'b0, "R10", "no pulse in reset", int'(resync_o), 0);

    ref_off = 1;
    start_run("R10");
    step_cycles(30);
    check(int'(resync_cnt_o) == 1, "R10", "count after restart", int'(resync_cnt_o), 1);
    check(pulse_q.size() == 0, "R5", "pending pulses", pulse_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule